// File: doc/BRIEF.md
# Ordered Store Buffer with Barrier Tokens

The block sits between an in-order core and a single memory port. The core hands it one request per cycle: a store, a load or a write barrier. Stores and barriers are queued. Loads are answered either from the youngest buffered store to the same address or by going straight to memory, ahead of any stores still in the queue.

A barrier does not stall the core. It is kept as a token entry in the queue, and stores from both sides of it can sit in the queue together. The drain sends stores to memory one per granted cycle, oldest first. A barrier token that reaches the head is dropped in one cycle and takes no memory-port cycle. Because of this, no store can reach memory before a barrier that was queued ahead of it.

Top module: `store_order_buffer`

## Requirements
- R1: After reset the queue is empty. `memReq` and `respValid` are low, and a store request sees `reqReady` high.
- R2: The request code on `reqKind` is 0 for a store, 1 for a load and 2 for a barrier. Accepted stores are written to memory (`memReq`=1, `memWe`=1) with their own address and data, in acceptance order. Each write leaves the port in a cycle where `memGnt` is high.
- R3: A load whose address matches no buffered store takes the memory port in the cycle it is presented (`memWe`=0, `memAddr` = load address), ahead of all buffered stores. `respValid` rises one cycle after acceptance with the memory data.
- R4: A load whose address matches buffered stores is accepted at once and makes no memory-port transaction. One cycle later it returns the data of the youngest matching store.
- R5: A barrier token at the head is removed in one cycle with no memory-port transaction. The last store before the barrier and the first store after it therefore reach the port exactly two cycles apart under a steady grant.
- R6: A barrier does not block the core. Stores presented after a barrier are accepted without wait cycles while the queue has room.
- R7: The queue holds DEPTH (default 8) entries. When it is full, stores and barriers see `reqReady` low, while a load that hits the queue is still accepted.
- R8: While `memGnt` is low, no store leaves the queue and the head store is offered again until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core request valid |
| reqKind | input | 2 | 0 store, 1 load, 2 barrier |
| reqAddr | input | ADDR_W | Request address |
| reqData | input | DATA_W | Store data |
| reqReady | output | 1 | Request accepted this cycle |
| respValid | output | 1 | Load result valid |
| respData | output | DATA_W | Load result |
| memReq | output | 1 | Memory port request |
| memWe | output | 1 | 1 write, 0 read |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memGnt | input | 1 | Memory accepts the request this cycle |
| memRdata | input | DATA_W | Read data, valid in the granted cycle |

## Verification
A load result appears one cycle after its accepting edge, whether it is forwarded or read from memory. A queued store can reach the port at the earliest in the cycle after its acceptance, and each barrier at the head adds one idle cycle between writes. The bench drives its inputs just after a rising edge and samples `reqReady`, the response pins and the port at the falling edge. It logs every granted port transaction together with its cycle number, so that order and spacing are compared against these latencies and not against fixed waits.

// File: rtl/sob_pkg.sv
package sob_pkg;
  typedef enum logic [1:0] {
    KIND_STORE   = 2'd0,
    KIND_LOAD    = 2'd1,
    KIND_BARRIER = 2'd2
  } reqKind_e;

  typedef struct packed {
    logic push;       // enqueue the current request
    logic pushBar;    // the enqueued entry is a barrier token
    logic pop;        // drop the head entry
    logic ldCapture;  // a load is accepted this cycle
    logic ldFromFwd;  // its data comes from the queue
  } qStrobe_t;
endpackage

// File: rtl/sob_datapath.sv
module sob_datapath
  import sob_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strobe,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [CNT_W-1:0]  count,
  output logic              headValid,
  output logic              headIsBar,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData,
  output logic              fwdHit,
  output logic [DATA_W-1:0] fwdData,
  output logic              respValid,
  output logic [DATA_W-1:0] respData
);
  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [DATA_W-1:0] entData [DEPTH];
  logic [DEPTH-1:0]  entBar;
  logic [CNT_W-1:0]  wrIdx;

  assign wrIdx = count - CNT_W'(strobe.pop);

  // Age-ordered entries: index 0 is the oldest, a pop shifts everything down.
  for (genvar g = 0; g < DEPTH; g++) begin : gEnt
    localparam int SRC = (g < DEPTH - 1) ? g + 1 : g;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entAddr[g] <= '0;
        entData[g] <= '0;
        entBar[g]  <= 1'b0;
      end else if (strobe.push && wrIdx == CNT_W'(g)) begin
        entAddr[g] <= inAddr;
        entData[g] <= inData;
        entBar[g]  <= strobe.pushBar;
      end else if (strobe.pop && g < DEPTH - 1) begin
        entAddr[g] <= entAddr[SRC];
        entData[g] <= entData[SRC];
        entBar[g]  <= entBar[SRC];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      respValid <= 1'b0;
      respData  <= '0;
    end else begin
      count     <= count + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
      respValid <= strobe.ldCapture;
      if (strobe.ldCapture) respData <= strobe.ldFromFwd ? fwdData : memRdata;
    end
  end

  // Youngest matching store wins: later indices overwrite earlier ones.
  always_comb begin
    fwdHit  = 1'b0;
    fwdData = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < count && !entBar[i] && entAddr[i] == inAddr) begin
        fwdHit  = 1'b1;
        fwdData = entData[i];
      end
    end
  end

  assign headValid = (count != '0);
  assign headIsBar = entBar[0];
  assign headAddr  = entAddr[0];
  assign headData  = entData[0];

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(DEPTH)) |-> !strobe.push);
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  p_resp_next_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldCapture |=> respValid);
endmodule

// File: rtl/sob_control.sv
module sob_control
  import sob_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              memGnt,
  input  logic [CNT_W-1:0]  count,
  input  logic              headValid,
  input  logic              headIsBar,
  input  logic [ADDR_W-1:0] headAddr,
  input  logic              fwdHit,
  output qStrobe_t          strobe,
  output logic              reqReady,
  output logic              memReq,
  output logic              memWe,
  output logic              memSelLoad
);
  logic isLoad, isEnq, hasRoom, loadMiss, drainReq;

  assign isLoad   = reqValid && reqKind == KIND_LOAD;
  assign isEnq    = reqValid && (reqKind == KIND_STORE || reqKind == KIND_BARRIER);
  assign hasRoom  = count < CNT_W'(DEPTH);
  assign loadMiss = isLoad && !fwdHit;
  // A missing load owns the port; stores only drain when it is free.
  assign drainReq = headValid && !headIsBar && !loadMiss;

  assign memReq     = loadMiss || drainReq;
  assign memWe      = !loadMiss;
  assign memSelLoad = loadMiss;

  always_comb begin
    if (reqKind == KIND_LOAD) reqReady = fwdHit || memGnt;
    else if (reqKind == KIND_STORE || reqKind == KIND_BARRIER) reqReady = hasRoom;
    else reqReady = 1'b0;
  end

  always_comb begin
    strobe.push      = isEnq && hasRoom;
    strobe.pushBar   = reqKind == KIND_BARRIER;
    strobe.pop       = (headValid && headIsBar) || (drainReq && memGnt);
    strobe.ldCapture = isLoad && (fwdHit || memGnt);
    strobe.ldFromFwd = fwdHit;
  end

  p_load_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadMiss |-> (memReq && !memWe));
  p_bar_no_port_r5: assert property (@(posedge clk) disable iff (!rstN)
    (headValid && headIsBar) |-> !(memReq && memWe));
  p_drain_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && !memGnt) |=> (headValid && !headIsBar && $stable(headAddr)));
  p_write_has_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (headValid && !headIsBar));
endmodule

// File: rtl/store_order_buffer.sv
module store_order_buffer
  import sob_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqReady,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memGnt,
  input  logic [DATA_W-1:0] memRdata
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  qStrobe_t          strobe;
  logic [CNT_W-1:0]  count;
  logic              headValid, headIsBar, fwdHit, memSelLoad;
  logic [ADDR_W-1:0] headAddr;
  logic [DATA_W-1:0] headData, fwdData;

  sob_control #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .memGnt(memGnt), .count(count), .headValid(headValid),
    .headIsBar(headIsBar), .headAddr(headAddr), .fwdHit(fwdHit),
    .strobe(strobe), .reqReady(reqReady), .memReq(memReq),
    .memWe(memWe), .memSelLoad(memSelLoad)
  );

  sob_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inAddr(reqAddr),
    .inData(reqData), .memRdata(memRdata), .count(count),
    .headValid(headValid), .headIsBar(headIsBar), .headAddr(headAddr),
    .headData(headData), .fwdHit(fwdHit), .fwdData(fwdData),
    .respValid(respValid), .respData(respData)
  );

  assign memAddr  = memSelLoad ? reqAddr : headAddr;
  assign memWdata = headData;
endmodule

// File: tb/store_order_buffer_test.sv
`timescale 1ns/1ps
module store_order_buffer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic        reqReady, respValid, memReq, memWe;
  logic [31:0] respData, memWdata, memRdata;
  logic [15:0] memAddr;
  logic        memGnt = 1'b0;

  int total = 0, failed = 0, cyc = 0, evN = 0;
  logic        evWe   [64];
  logic [15:0] evAddr [64];
  logic [31:0] evData [64];
  int          evCyc  [64];

  always #2 clk = ~clk;
  assign memRdata = {16'h0, memAddr} * 32'd3 + 32'd7;

  store_order_buffer uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqData(reqData), .reqReady(reqReady),
    .respValid(respValid), .respData(respData), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memGnt(memGnt), .memRdata(memRdata)
  );

  always @(negedge clk) begin
    cyc++;
    if (rstN && memReq && memGnt && evN < 64) begin
      evWe[evN] = memWe; evAddr[evN] = memAddr;
      evData[evN] = memWdata; evCyc[evN] = cyc;
      evN++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] kind, input logic [15:0] a, input logic [31:0] d,
                      output int waits, output logic [31:0] rd);
    waits = 0; rd = '0;
    @(posedge clk); #1;
    reqValid = 1'b1; reqKind = kind; reqAddr = a; reqData = d;
    @(negedge clk);
    while (!reqReady && waits < 100) begin waits++; @(negedge clk); end
    @(posedge clk); #1;
    reqValid = 1'b0;
    if (kind == 2'd1) begin
      @(negedge clk);
      check("R3/R4 respValid", {31'b0, respValid}, 32'd1);
      rd = respData;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 memReq", {31'b0, memReq}, 32'd0);
    check("R1 respValid", {31'b0, respValid}, 32'd0);
    check("R1 reqReady", {31'b0, reqReady}, 32'd1);
  endtask

  task automatic t_drain_order;
    int w; logic [31:0] rd; int base;
    base = evN; memGnt = 1'b1;
    for (int i = 0; i < 3; i++) send(2'd0, 16'h0100 + 16'(i), 32'hA000 + 32'(i), w, rd);
    idle(4);
    check("R2 write count", 32'(evN - base), 32'd3);
    for (int i = 0; i < 3; i++) begin
      check("R2 write kind", {31'b0, evWe[base+i]}, 32'd1);
      check("R2 write addr", {16'h0, evAddr[base+i]}, 32'h0100 + 32'(i));
      check("R2 write data", evData[base+i], 32'hA000 + 32'(i));
    end
  endtask

  task automatic t_forward_and_stall;
    int w; logic [31:0] rd; int base;
    memGnt = 1'b0; base = evN;
    send(2'd0, 16'h0010, 32'h1, w, rd);
    send(2'd0, 16'h0010, 32'h2, w, rd);
    send(2'd0, 16'h0011, 32'h3, w, rd);
    idle(5);
    check("R8 no write without grant", 32'(evN - base), 32'd0);
    send(2'd1, 16'h0010, 32'h0, w, rd);
    check("R4 youngest data", rd, 32'h2);
    check("R4 no wait", 32'(w), 32'd0);
    check("R4 no port transaction", 32'(evN - base), 32'd0);
    memGnt = 1'b1;
    idle(6);
    check("R8 held stores drain", 32'(evN - base), 32'd3);
    check("R8 first held addr", {16'h0, evAddr[base]}, 32'h0010);
  endtask

  task automatic t_bypass;
    int w; logic [31:0] rd; int base;
    memGnt = 1'b0;
    send(2'd0, 16'h0020, 32'h20, w, rd);
    base = evN;
    fork
      send(2'd1, 16'h0030, 32'h0, w, rd);
      begin idle(3); memGnt = 1'b1; end
    join
    idle(3);
    check("R3 load first kind", {31'b0, evWe[base]}, 32'd0);
    check("R3 load first addr", {16'h0, evAddr[base]}, 32'h0030);
    check("R3 load data", rd, 32'h0030 * 3 + 7);
    check("R3 store after load", {16'h0, evAddr[base+1]}, 32'h0020);
  endtask

  task automatic t_barrier;
    int w; logic [31:0] rd; int base;
    memGnt = 1'b0; base = evN;
    send(2'd0, 16'h0040, 32'h40, w, rd);
    send(2'd2, 16'h0000, 32'h0, w, rd);
    check("R6 barrier accepted at once", 32'(w), 32'd0);
    send(2'd0, 16'h0041, 32'h41, w, rd);
    check("R6 store after barrier no wait", 32'(w), 32'd0);
    memGnt = 1'b1;
    idle(6);
    check("R5 two writes only", 32'(evN - base), 32'd2);
    check("R5 older store first", {16'h0, evAddr[base]}, 32'h0040);
    check("R5 younger store second", {16'h0, evAddr[base+1]}, 32'h0041);
    check("R5 one idle cycle for token", 32'(evCyc[base+1] - evCyc[base]), 32'd2);
  endtask

  task automatic t_full;
    int w; logic [31:0] rd; int base;
    memGnt = 1'b0; base = evN;
    for (int i = 0; i < 8; i++) send(2'd0, 16'h0050 + 16'(i), 32'h500 + 32'(i), w, rd);
    @(posedge clk); #1;
    reqValid = 1'b1; reqKind = 2'd0; reqAddr = 16'h0060;
    @(negedge clk);
    check("R7 store refused when full", {31'b0, reqReady}, 32'd0);
    @(posedge clk); #1;
    reqKind = 2'd2;
    @(negedge clk);
    check("R7 barrier refused when full", {31'b0, reqReady}, 32'd0);
    @(posedge clk); #1;
    reqValid = 1'b0;
    send(2'd1, 16'h0053, 32'h0, w, rd);
    check("R7 load accepted when full", 32'(w), 32'd0);
    check("R7 load data when full", rd, 32'h503);
    memGnt = 1'b1;
    idle(12);
    check("R7 all eight drained", 32'(evN - base), 32'd8);
    for (int i = 0; i < 8; i++)
      check("R7 drain order", {16'h0, evAddr[base+i]}, 32'h0050 + 32'(i));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_drain_order();
    t_forward_and_stall();
    t_bypass();
    t_barrier();
    t_full();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule